// File: doc/BRIEF.md
# Frame-Synchronized Interval Timer

This block provides two interval timers for a synthesis chip whose master clock is divided into sample frames of fixed length. A frame position counter walks through the cycles of each frame. A free-running 2-bit prescaler steps once per frame at a fixed position. Its carry produces the tick of a fast timer, and a further divide-by-four stage produces the tick of a slow timer. Each timer is an 8-bit up-counter with a preset register. Software loads the preset, sets the run bit, and gets an active-low interrupt when the counter wraps.

The interrupt is never raised at the moment of overflow. An overflow is held pending and is turned into a sticky flag at one fixed position of the frame. The interrupt line therefore always falls on the same cycle of a frame. The prescaler and the slow divider keep their values through a chip reset, while the reset restarts the frame phase. This means the frame in which the interrupt lands depends on how many frames have passed since power-up, and not only on the moment the timer was started. A reset takes effect only when the reset input stays low long enough, so short glitches are filtered out.

Top module: `frame_timer`

## Requirements
- R1: The frame position runs 0 to 71 and then wraps. The interrupt output only falls in a cycle whose frame position is 16. The first cycle after the reset input returns high is position 0.
- R2: The 2-bit prescaler steps at the clock edge that ends frame position 2. A fast tick occurs when the prescaler wraps from 3 to 0, so the fast tick period is 288 cycles.
- R3: The slow timer ticks on every fourth fast tick, so its tick period is 1152 cycles.
- R4: A chip reset happens only after the reset input has been low for at least 80 consecutive cycles. A shorter low pulse leaves the frame phase, the timers and the flags untouched.
- R5: A chip reset sets the frame position to 0 and clears the presets, run bits, mask bits, counts and flags, so the interrupt output goes high. The prescaler and the slow divider keep their values.
- R6: A control write (ctrl_we with wdata bit 0 for fast, bit 1 for slow) that sets a stopped timer running makes that timer load its preset at its next tick. Each later tick adds one. A tick when the count is 255 is an overflow and reloads the preset.
- R7: An overflow sets the timer's flag at the edge that ends frame position 15 of the same frame, so the interrupt output is low from position 16 on. The flags are sticky. The interrupt output is low exactly while any flag is set.
- R8: irq_clr clears all flags at the next edge, so the interrupt output is high in the following cycle. A flag that is set at that same edge survives the clear.
- R9: Control-write bits wdata[2] (fast) and wdata[3] (slow) are mask bits. A masked timer keeps counting, but its overflows set no flag.
- R10: A control write with a timer's run bit at 0 freezes its count and stops its overflows. Setting the run bit again reloads the preset at the next tick.
- R11: load_fast and load_slow copy wdata into the preset of that timer. The new preset is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low chip reset, filtered by length |
| wdata | input | 8 | Write data for presets and control |
| load_fast | input | 1 | Strobe: write fast timer preset |
| load_slow | input | 1 | Strobe: write slow timer preset |
| ctrl_we | input | 1 | Strobe: write run bits [1:0] and mask bits [3:2] |
| irq_clr | input | 1 | Strobe: clear all interrupt flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: a 72-cycle frame, the prescaler step at position 2, the interrupt at position 16, an 80-cycle reset hold, 8-bit counters and a slow ratio of 4. With presets near 255, overflows come every few ticks. This puts several slow-timer periods of 1152 cycles, many resets with different prescaler phases, and reset pulses just below and above the 80-cycle hold within a short run. Directed cases measure the cycle distance between interrupts and their frame position. A random phase compares the interrupt line on every cycle with a model that counts frames since power-up.

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int FRAME_CYCLES = 72,
  parameter int STEP_POS     = 2,
  parameter int IRQ_POS      = 16,
  parameter int RST_HOLD     = 80,
  parameter int CNT_W        = 8,
  parameter int SLOW_RATIO   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wdata,
  input  logic             load_fast,
  input  logic             load_slow,
  input  logic             ctrl_we,
  input  logic             irq_clr,
  output logic             irq_n
);
  localparam int POS_W  = $clog2(FRAME_CYCLES);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam int SR_W   = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [POS_W-1:0]  LAST_POS = POS_W'(FRAME_CYCLES - 1);
  localparam logic [POS_W-1:0]  TICK_AT  = POS_W'(STEP_POS);
  localparam logic [POS_W-1:0]  FLAG_AT  = POS_W'(IRQ_POS - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(RST_HOLD);
  localparam logic [SR_W-1:0]   SR_LAST  = SR_W'(SLOW_RATIO - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [HOLD_W-1:0] low_cnt = '0;
  logic [1:0]        presc   = '0;
  logic [SR_W-1:0]   sdiv    = '0;
  logic [POS_W-1:0]  pos;

  logic [1:0][CNT_W-1:0] preset, cnt;
  logic [1:0] run, pend, mask, ovp, flag;
  logic [1:0] tick, ovf;

  wire chip_rst = (low_cnt == HOLD_MAX);
  wire at_step  = !chip_rst && (pos == TICK_AT);
  wire at_flag  = !chip_rst && (pos == FLAG_AT);

  assign tick[0] = at_step && (presc == 2'd3);
  assign tick[1] = tick[0] && (sdiv == SR_LAST);
  assign irq_n   = ~|flag;

  always_ff @(posedge clk) begin
    if (rst_n)          low_cnt <= '0;
    else if (!chip_rst) low_cnt <= low_cnt + HOLD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (chip_rst)             pos <= '0;
    else if (pos == LAST_POS) pos <= '0;
    else                      pos <= pos + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (at_step) presc <= presc + 2'd1;
    if (tick[0]) sdiv  <= (sdiv == SR_LAST) ? '0 : sdiv + SR_W'(1);
  end

  always_comb
    for (int i = 0; i < 2; i++)
      ovf[i] = tick[i] && run[i] && !pend[i] && (cnt[i] == CNT_MAX);

  always_ff @(posedge clk) begin
    if (chip_rst) begin
      preset <= '0;
      cnt    <= '0;
      run    <= '0;
      pend   <= '0;
      mask   <= '0;
      ovp    <= '0;
      flag   <= '0;
    end else begin
      if (load_fast) preset[0] <= wdata;
      if (load_slow) preset[1] <= wdata;
      flag <= (irq_clr ? 2'b00 : flag) | (at_flag ? ovp : 2'b00);
      ovp  <= (at_flag ? 2'b00 : ovp) | (ovf & ~mask);
      for (int i = 0; i < 2; i++) begin
        if (tick[i] && run[i]) begin
          if (pend[i]) begin
            cnt[i]  <= preset[i];
            pend[i] <= 1'b0;
          end else if (ovf[i]) begin
            cnt[i] <= preset[i];
          end else begin
            cnt[i] <= cnt[i] + CNT_W'(1);
          end
        end
        if (ctrl_we && wdata[i] && !run[i]) pend[i] <= 1'b1;
      end
      if (ctrl_we) begin
        run  <= wdata[1:0];
        mask <= wdata[3:2];
      end
    end
  end
endmodule

// File: rtl/frame_timer_chk.sv
module frame_timer_chk #(
  parameter int FRAME_CYCLES = 72,
  parameter int STEP_POS     = 2,
  parameter int IRQ_POS      = 16,
  parameter int RST_HOLD     = 80,
  parameter int CNT_W        = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  chip_rst,
  input logic [$clog2(FRAME_CYCLES)-1:0] pos,
  input logic [1:0]            presc,
  input logic [1:0]            run,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic                  irq_clr,
  input logic                  irq_n
);
  localparam int POS_W  = $clog2(FRAME_CYCLES);
  localparam int LOWS_W = $clog2(RST_HOLD + 2);

  logic [LOWS_W-1:0] lows = '0;
  always_ff @(posedge clk)
    if (rst_n) lows <= '0;
    else if (lows <= LOWS_W'(RST_HOLD)) lows <= lows + LOWS_W'(1);

  p_irq_pos_r1: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    $fell(irq_n) |-> pos == POS_W'(IRQ_POS));

  p_pos_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    pos == POS_W'(FRAME_CYCLES - 1) |=> pos == '0);

  p_presc_step_r2: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    pos == POS_W'(STEP_POS) |=> presc == $past(presc) + 2'd1);

  p_presc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    pos != POS_W'(STEP_POS) |=> $stable(presc));

  p_rst_len_r4: assert property (@(posedge clk) disable iff (rst_n)
    $rose(chip_rst) |-> lows >= LOWS_W'(RST_HOLD));

  p_presc_kept_r5: assert property (@(posedge clk) disable iff (rst_n)
    chip_rst |=> $stable(presc));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    !irq_n && !irq_clr |=> !irq_n);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    irq_clr && pos != POS_W'(IRQ_POS - 1) |=> irq_n);

  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    !run[0] |=> $stable(cnt[0]));

  p_stop_freeze_slow_r10: assert property (@(posedge clk) disable iff (!rst_n || chip_rst)
    !run[1] |=> $stable(cnt[1]));
endmodule

bind frame_timer frame_timer_chk #(
  .FRAME_CYCLES(FRAME_CYCLES), .STEP_POS(STEP_POS), .IRQ_POS(IRQ_POS),
  .RST_HOLD(RST_HOLD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .pos(pos), .presc(presc),
  .run(run), .cnt(cnt), .irq_clr(irq_clr), .irq_n(irq_n)
);

// File: tb/sim_frame_timer.sv
module sim_frame_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] wdata = '0;
  logic load_fast = 0, load_slow = 0, ctrl_we = 0, irq_clr = 0;
  logic irq_n;

  int checks = 0, fails = 0, rel = 0;
  bit armed = 0;
  string tag = "R5";

  frame_timer u0 (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .load_fast(load_fast),
    .load_slow(load_slow), .ctrl_we(ctrl_we), .irq_clr(irq_clr), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_low = 0, m_pos = 0, m_sd = 0;
  bit [1:0] m_pre = 0;
  int m_cnt[2], m_ps[2];
  bit m_run[2], m_pend[2], m_mask[2], m_ovp[2], m_flag[2];

  initial for (int i = 0; i < 2; i++) begin
    m_cnt[i] = 0; m_ps[i] = 0; m_run[i] = 0; m_pend[i] = 0;
    m_mask[i] = 0; m_ovp[i] = 0; m_flag[i] = 0;
  end

  always @(posedge clk) begin : model
    bit crst, tk;
    bit t[2];
    crst = (m_low >= 80);
    m_low = rst_n ? 0 : (m_low >= 80 ? 80 : m_low + 1);
    if (crst) begin
      m_pos = 0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_ps[i] = 0; m_run[i] = 0; m_pend[i] = 0;
        m_mask[i] = 0; m_ovp[i] = 0; m_flag[i] = 0;
      end
    end else begin
      tk = (m_pos == 2);
      t[0] = tk && (m_pre == 2'd3);
      t[1] = t[0] && (m_sd == 3);
      if (tk) m_pre = m_pre + 2'd1;
      if (t[0]) m_sd = (m_sd + 1) % 4;
      if (irq_clr) begin m_flag[0] = 0; m_flag[1] = 0; end
      if (m_pos == 15)
        for (int i = 0; i < 2; i++) begin
          m_flag[i] = m_flag[i] | m_ovp[i];
          m_ovp[i] = 0;
        end
      for (int i = 0; i < 2; i++) begin
        if (t[i] && m_run[i]) begin
          if (m_pend[i]) begin m_cnt[i] = m_ps[i]; m_pend[i] = 0; end
          else if (m_cnt[i] == 255) begin
            m_cnt[i] = m_ps[i];
            if (!m_mask[i]) m_ovp[i] = 1;
          end else m_cnt[i] = m_cnt[i] + 1;
        end
        if (ctrl_we && wdata[i] && !m_run[i]) m_pend[i] = 1;
      end
      if (load_fast) m_ps[0] = wdata;
      if (load_slow) m_ps[1] = wdata;
      if (ctrl_we) begin
        m_run[0] = wdata[0]; m_run[1] = wdata[1];
        m_mask[0] = wdata[2]; m_mask[1] = wdata[3];
      end
      m_pos = (m_pos + 1) % 72;
    end
  end

  function automatic bit model_irq_n();
    return !(m_flag[0] || m_flag[1]);
  endfunction

  task automatic check(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rel++;
    if (armed) check(irq_n === model_irq_n(), tag, int'(irq_n), int'(model_irq_n()));
  endtask

  task automatic wait_fall(int maxc, output int at, output bit ok);
    ok = 0; at = -1;
    for (int n = 0; n < maxc; n++) begin
      step();
      if (irq_n == 1'b0) begin ok = 1; at = rel; return; end
    end
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_we = 1; wdata = v; step(); ctrl_we = 0;
  endtask

  task automatic clear();
    irq_clr = 1; step(); irq_clr = 0;
  endtask

  task automatic long_reset(int len);
    rst_n = 0;
    repeat (len) step();
    rst_n = 1; rel = -1;
    step();
  endtask

  task automatic phase_test();
    int p0, k0, at, at2, at3, expv;
    bit ok;
    p0 = int'(m_pre);
    k0 = (3 - p0) & 3;
    load_fast = 1; wdata = 8'hff; step(); load_fast = 0;
    wr_ctrl(8'h01);
    wait_fall(1000, at, ok);
    expv = (k0 + 4) * 72 + 16;
    check(ok && at == expv, "R5 R6 first fall cycle", at, expv);
    repeat (200) step();
    check(irq_n == 1'b0, "R7 flag sticky", int'(irq_n), 0);
    clear();
    check(irq_n == 1'b1, "R8 clear", int'(irq_n), 1);
    wait_fall(1000, at2, ok);
    check(ok && at2 - at == 288, "R2 fast period", at2 - at, 288);
    check(at2 % 72 == 16, "R1 fall position", at2 % 72, 16);
    clear();
    wait_fall(1000, at3, ok);
    check(ok && at3 - at2 == 288, "R2 fast period repeat", at3 - at2, 288);
    wr_ctrl(8'h00);
    clear();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rel, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int at, at2;
    bit ok, low_seen;
    void'($urandom(32'd2417));
    long_reset(100);
    armed = 1;
    check(irq_n == 1'b1, "R5 reset state", int'(irq_n), 1);

    tag = "R1 R2 R6";
    phase_test();

    tag = "R10";
    low_seen = 0;
    for (int n = 0; n < 20 * 72; n++) begin step(); if (!irq_n) low_seen = 1; end
    check(!low_seen, "R10 stopped timer silent", int'(low_seen), 0);

    tag = "R3";
    load_slow = 1; wdata = 8'hff; step(); load_slow = 0;
    wr_ctrl(8'h02);
    wait_fall(3000, at, ok);
    check(ok && at % 72 == 16, "R3 slow fall position", at % 72, 16);
    clear();
    wait_fall(3000, at2, ok);
    check(ok && at2 - at == 1152, "R3 slow period", at2 - at, 1152);
    wr_ctrl(8'h00);
    clear();
    check(irq_n == 1'b1, "R8 clear after slow", int'(irq_n), 1);

    tag = "R9";
    wr_ctrl(8'h05);
    low_seen = 0;
    for (int n = 0; n < 12 * 72; n++) begin step(); if (!irq_n) low_seen = 1; end
    check(!low_seen, "R9 masked timer", int'(low_seen), 0);
    wr_ctrl(8'h00);

    tag = "R4";
    wr_ctrl(8'h01);
    wait_fall(2000, at, ok);
    check(ok, "R4 fall before pulse", int'(ok), 1);
    rst_n = 0; repeat (50) step(); rst_n = 1;
    step();
    check(irq_n == 1'b0, "R4 short pulse ignored", int'(irq_n), 0);
    clear();
    wait_fall(2000, at2, ok);
    check(ok && at2 % 72 == 16, "R4 frame phase kept", at2 % 72, 16);
    check((at2 - at) % 288 == 0, "R4 tick phase kept", (at2 - at) % 288, 0);

    tag = "R5";
    long_reset(90);
    check(irq_n == 1'b1, "R5 reset clears flags", int'(irq_n), 1);
    phase_test();
    long_reset(81);
    phase_test();

    tag = "R6 R11";
    for (int n = 0; n < 25000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3) begin load_fast = 1; wdata = 8'(248 + $urandom % 8); end
      else if (r < 6) begin load_slow = 1; wdata = 8'(240 + $urandom % 16); end
      else if (r < 9) begin ctrl_we = 1; wdata = 8'($urandom % 16); end
      else if (r < 12) irq_clr = 1;
      else if (r == 99 && ($urandom % 30) == 0) begin
        rst_n = 0;
        repeat (60 + $urandom % 40) step();
        rst_n = 1;
      end
      step();
      load_fast = 0; load_slow = 0; ctrl_we = 0; irq_clr = 0;
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule